// File: doc/BRIEF.md
# Tiered Bus Arbiter with Promotion

This block arbitrates ownership of a shared parallel bus behind a bridge. Requester 0 is the bridge's own master. The other indices are external masters. Each requester raises a request line. The arbiter answers with at most one grant line. A master that holds the grant starts its transaction by driving the frame signal. Each requester has a configuration bit that puts it in the high or the low priority tier. Order rotates inside each tier, and the low tier gets one slot each time the high-tier rotation wraps.

An optional enhancement moves a master into the high tier on the fly. This happens when the master has just been retried or has a delayed transaction outstanding. The master keeps that status until it has been granted and has started a transaction. When nobody requests, the free bus is parked on the bridge or on the last master that used it, chosen by an input. A grant timer withdraws a grant the owner does not use in time and moves on. A separate enable turns that event into a one-cycle system-error pulse.

Top module: `tier_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt` is set in any cycle. Reset is synchronous and active high. After reset, `gnt` is `00001` (the bridge, index 0), `serr` is 0 and no requester is promoted.
- R2: The grant is updated only at an edge where `frame` is sampled 0, which covers an idle bus and the last data phase. After an edge with `frame` at 1, `gnt` is unchanged.
- R3: `tier_hi[i]`=1 puts requester i in the high tier. A free bus picks the next high-tier requester after the last high-tier winner, in ascending index order with wrap. If that choice wraps to an index no greater than the last high winner, a low tier request is pending, and the previous grant was not a low-tier slot, the low-tier candidate is granted first. After reset, the last-winner pointers start at the top index.
- R4: Low-tier requesters rotate the same way among themselves, starting after the last low-tier winner.
- R5: When `promo_en` is 1, a requester whose `retried` bit is 1 at an edge is treated as high tier from the next cycle. It stays there until an edge where it holds the grant and `frame` is 1. A new set event wins over that clear.
- R6: When `promo_en` is 1, a requester whose `dly_pend` bit is 1 is promoted in the same way and for as long as the bit is held.
- R7: When `promo_en` is 0, `retried` and `dly_pend` have no effect on order, and all promotions are dropped at the next edge.
- R8: With no request and a free bus, the grant parks at the next edge. With `park_bridge`=1 it parks on index 0. With `park_bridge`=0 it parks on the last index that held the grant while `frame` was 1, or on index 0 if none has since reset.
- R9: A grant issued to a requester starts a 16-edge window. If `frame` is 0 at all 16 following edges, `gnt` is all zero for one cycle. Arbitration then resumes. Requests are not re-arbitrated while the window is open.
- R10: `serr` is a one-cycle pulse that coincides with the zero-grant cycle of R9, and only if `serr_on_timeout` was 1 at the expiring edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NREQ | Request lines, bit 0 is the bridge |
| tier_hi | input | NREQ | Base tier per requester, 1 = high |
| promo_en | input | 1 | Enables promotion of retried or delayed masters |
| retried | input | NREQ | Pulse: that master was just retried |
| dly_pend | input | NREQ | Level: that master has a delayed transaction pending |
| park_bridge | input | 1 | 1 = park free bus on bridge, 0 = on last user |
| serr_on_timeout | input | 1 | Enables the error pulse on grant timeout |
| frame | input | 1 | Bus frame, active high |
| gnt | output | NREQ | One-hot grant lines |
| serr | output | 1 | One-cycle error pulse on grant timeout |

## Verification
A corrupted rotation pointer or alternation flag appears at the ports at the next free-bus decision. The wrong master receives `gnt` within one transaction. A stale promotion flag shifts the order within one high-tier round. A wrong timer count moves the drop of `gnt` and the `serr` pulse away from the 16th idle edge after the grant. The bench keeps a behavioural model of the grant order, the parking choice and the timer, and it compares `gnt` and `serr` with that model on every cycle. Any such fault therefore shows within a few cycles of the decision it affects.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        PH_OPEN = 1'b0,
        PH_WAIT = 1'b1
    } arb_phase_e;

    typedef struct packed {
        logic valid;
        logic low_tier;
    } arb_pick_s;

    localparam int ARB_MASK_W = 32;

    // First set bit strictly after ptr, rotating over n entries; -1 if none.
    function automatic int next_set(input logic [ARB_MASK_W-1:0] mask,
                                    input int ptr, input int n);
        int found;
        found = -1;
        for (int k = 1; k <= ARB_MASK_W; k++) begin
            if (k <= n && found < 0) begin
                if (mask[(ptr + k) % n]) found = (ptr + k) % n;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/arb_promote.sv
module arb_promote
    import arb_pkg::*;
#(
    parameter int NREQ = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            promo_en,
    input  logic [NREQ-1:0] retried,
    input  logic [NREQ-1:0] dly_pend,
    input  logic [NREQ-1:0] tier_hi,
    input  logic [NREQ-1:0] gnt,
    input  logic            frame,
    output logic [NREQ-1:0] hi_eff
);

    logic [NREQ-1:0] promoted;

    for (genvar i = 0; i < NREQ; i++) begin : g_flag
        logic began;
        assign began = gnt[i] & frame;

        always_ff @(posedge clk) begin
            if (rst) begin
                promoted[i] <= 1'b0;
            end else begin
                promoted[i] <= promo_en &
                               (retried[i] | dly_pend[i] | (promoted[i] & ~began));
            end
        end

        a_r5_retry_lifts: assert property (@(posedge clk) disable iff (rst)
            promo_en && retried[i] |=> hi_eff[i]);

        a_r6_delay_lifts: assert property (@(posedge clk) disable iff (rst)
            promo_en && dly_pend[i] |=> hi_eff[i]);
    end

    assign hi_eff = tier_hi | promoted;

    a_r7_off_drops_all: assert property (@(posedge clk) disable iff (rst)
        !promo_en |=> hi_eff == tier_hi);

endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int NREQ = 5,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req,
    input  logic [NREQ-1:0] hi_eff,
    input  logic [IW-1:0]   hi_ptr,
    input  logic [IW-1:0]   lo_ptr,
    input  logic            lo_done,
    output arb_pick_s       pick,
    output logic [IW-1:0]   win
);

    logic [NREQ-1:0] hreq, lreq;
    int hi_cand, lo_cand;
    logic wrapped;

    assign hreq = req & hi_eff;
    assign lreq = req & ~hi_eff;

    always_comb begin
        hi_cand = next_set(ARB_MASK_W'(hreq), int'(hi_ptr), NREQ);
        lo_cand = next_set(ARB_MASK_W'(lreq), int'(lo_ptr), NREQ);
        wrapped = (hi_cand >= 0) && (hi_cand <= int'(hi_ptr));
        pick    = '0;
        win     = '0;
        if (hi_cand >= 0) begin
            pick.valid = 1'b1;
            if (lo_cand >= 0 && wrapped && !lo_done) begin
                pick.low_tier = 1'b1;
                win           = IW'(lo_cand);
            end else begin
                win = IW'(hi_cand);
            end
        end else if (lo_cand >= 0) begin
            pick.valid    = 1'b1;
            pick.low_tier = 1'b1;
            win           = IW'(lo_cand);
        end
    end

    a_r3_winner_requests: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> req[win]);

    a_r3_high_is_high: assert property (@(posedge clk) disable iff (rst)
        pick.valid && !pick.low_tier |-> hi_eff[win]);

    a_r4_low_is_low: assert property (@(posedge clk) disable iff (rst)
        pick.valid && pick.low_tier |-> !hi_eff[win]);

endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
    parameter int TMO = 16,
    localparam int TW = (TMO > 1) ? $clog2(TMO) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expire
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == TW'(TMO - 1));

    a_r9_start_run_apart: assert property (@(posedge clk) disable iff (rst)
        !(start && run));

endmodule

// File: rtl/tier_bus_arbiter.sv
module tier_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NREQ = 5,
    parameter int TMO  = 16,
    localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req,
    input  logic [NREQ-1:0] tier_hi,
    input  logic            promo_en,
    input  logic [NREQ-1:0] retried,
    input  logic [NREQ-1:0] dly_pend,
    input  logic            park_bridge,
    input  logic            serr_on_timeout,
    input  logic            frame,
    output logic [NREQ-1:0] gnt,
    output logic            serr
);

    arb_phase_e      phase;
    logic [IW-1:0]   hi_ptr, lo_ptr, last_idx, gnt_idx, win;
    logic            lo_done;
    logic [NREQ-1:0] hi_eff;
    arb_pick_s       pick;
    logic            tmo_start, tmo_run, tmo_hit;

    function automatic logic [NREQ-1:0] dec(input logic [IW-1:0] k);
        logic [NREQ-1:0] v;
        v    = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (gnt[i]) gnt_idx = IW'(i);
        end
    end

    arb_promote #(.NREQ(NREQ)) u_promote (
        .clk(clk), .rst(rst), .promo_en(promo_en), .retried(retried),
        .dly_pend(dly_pend), .tier_hi(tier_hi), .gnt(gnt), .frame(frame),
        .hi_eff(hi_eff)
    );

    arb_pick #(.NREQ(NREQ)) u_pick (
        .clk(clk), .rst(rst), .req(req), .hi_eff(hi_eff), .hi_ptr(hi_ptr),
        .lo_ptr(lo_ptr), .lo_done(lo_done), .pick(pick), .win(win)
    );

    assign tmo_start = (phase == PH_OPEN) && !frame && pick.valid;
    assign tmo_run   = (phase == PH_WAIT) && !frame;

    arb_timer #(.TMO(TMO)) u_timer (
        .clk(clk), .rst(rst), .start(tmo_start), .run(tmo_run), .expire(tmo_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_OPEN;
            gnt      <= dec('0);
            hi_ptr   <= IW'(NREQ - 1);
            lo_ptr   <= IW'(NREQ - 1);
            lo_done  <= 1'b0;
            last_idx <= '0;
            serr     <= 1'b0;
        end else begin
            serr <= tmo_hit & serr_on_timeout;
            if (frame && (gnt != '0)) last_idx <= gnt_idx;
            unique case (phase)
                PH_WAIT: begin
                    if (frame) begin
                        phase <= PH_OPEN;
                    end else if (tmo_hit) begin
                        gnt   <= '0;
                        phase <= PH_OPEN;
                    end
                end
                PH_OPEN: begin
                    if (!frame) begin
                        if (pick.valid) begin
                            gnt   <= dec(win);
                            phase <= PH_WAIT;
                            if (pick.low_tier) begin
                                lo_ptr  <= win;
                                lo_done <= 1'b1;
                            end else begin
                                hi_ptr  <= win;
                                lo_done <= 1'b0;
                            end
                        end else begin
                            gnt <= park_bridge ? dec('0) : dec(last_idx);
                        end
                    end
                end
                default: phase <= PH_OPEN;
            endcase
        end
    end

    a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    a_r2_hold_in_frame: assert property (@(posedge clk) disable iff (rst)
        frame |=> gnt == $past(gnt));

    a_r8_park_on_bridge: assert property (@(posedge clk) disable iff (rst)
        phase == PH_OPEN && !frame && req == '0 && park_bridge |=> gnt == dec('0));

    a_r8_park_on_last: assert property (@(posedge clk) disable iff (rst)
        phase == PH_OPEN && !frame && req == '0 && !park_bridge
        |=> gnt == dec($past(last_idx)));

    a_r9_timeout_drops: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> gnt == '0);

    a_r10_serr_gated: assert property (@(posedge clk) disable iff (rst)
        serr |-> $past(serr_on_timeout) && gnt == '0);

    a_r10_serr_single: assert property (@(posedge clk) disable iff (rst)
        serr |=> !serr);

endmodule

// File: tb/tier_bus_arbiter_test.sv
`timescale 1ns/1ps
module tier_bus_arbiter_test;

    localparam int N   = 5;
    localparam int TMO = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req, tier_hi, retried, dly_pend, resp;
    logic         promo_en, park_bridge, serr_on_timeout, frame;
    logic [N-1:0] gnt;
    logic         serr;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [N-1:0] m_gnt, m_prom;
    logic         m_wait, m_lodone, m_serr;
    int           m_t, m_hp, m_lp, m_last;

    // bus master emulation
    int fcnt = 0;
    int last_user = 0;
    int starts[$];

    always #10 clk = ~clk;

    tier_bus_arbiter uut (
        .clk(clk), .rst(rst), .req(req), .tier_hi(tier_hi), .promo_en(promo_en),
        .retried(retried), .dly_pend(dly_pend), .park_bridge(park_bridge),
        .serr_on_timeout(serr_on_timeout), .frame(frame), .gnt(gnt), .serr(serr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: cycles actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int rr(input logic [N-1:0] m, input int p);
        for (int k = 1; k <= N; k++) begin
            if (m[(p + k) % N]) return (p + k) % N;
        end
        return -1;
    endfunction

    function automatic int idx_of(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic model_update();
        logic [N-1:0] eff, nprom;
        int h, l, w, gi;
        logic low;
        if (rst) begin
            m_gnt = 1; m_wait = 0; m_t = 0; m_hp = N - 1; m_lp = N - 1;
            m_lodone = 0; m_prom = '0; m_last = 0; m_serr = 0;
            return;
        end
        eff = tier_hi | m_prom;
        for (int i = 0; i < N; i++)
            nprom[i] = promo_en && (retried[i] || dly_pend[i] ||
                                    (m_prom[i] && !(m_gnt[i] && frame)));
        gi = idx_of(m_gnt);
        m_serr = 0;
        if (frame && gi >= 0) m_last = gi;
        if (m_wait) begin
            if (frame) m_wait = 0;
            else if (m_t == TMO - 1) begin
                m_gnt = '0; m_wait = 0; m_serr = serr_on_timeout;
            end else m_t++;
        end else if (!frame) begin
            h = rr(req & eff, m_hp);
            l = rr(req & ~eff, m_lp);
            w = -1; low = 0;
            if (h >= 0) begin
                if (l >= 0 && h <= m_hp && !m_lodone) begin w = l; low = 1; end
                else w = h;
            end else if (l >= 0) begin
                w = l; low = 1;
            end
            if (w >= 0) begin
                m_gnt = '0; m_gnt[w] = 1'b1; m_wait = 1; m_t = 0;
                if (low) begin m_lp = w; m_lodone = 1; end
                else begin m_hp = w; m_lodone = 0; end
            end else begin
                m_gnt = '0;
                if (park_bridge) m_gnt[0] = 1'b1; else m_gnt[m_last] = 1'b1;
            end
        end
        m_prom = nprom;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        checks++;
        if (gnt !== m_gnt || serr !== m_serr) begin
            errors++;
            $display("FAIL %s: gnt=%b serr=%b expected gnt=%b serr=%b",
                     cur_req, gnt, serr, m_gnt, m_serr);
        end
        checks++;
        if ($countones(gnt) > 1) begin
            errors++;
            $display("FAIL R1: grant bits actual=%0d expected<=1", $countones(gnt));
        end
    endtask

    task automatic emulate();
        if (fcnt > 0) begin
            fcnt--;
            if (fcnt == 0) frame = 1'b0;
        end else if (!frame && (gnt & req & resp) != '0) begin
            frame = 1'b1;
            fcnt = 3;
            last_user = idx_of(gnt);
            starts.push_back(last_user);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        emulate();
    endtask

    task automatic do_reset();
        rst = 1'b1; frame = 1'b0; fcnt = 0; req = '0; retried = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        starts.delete();
    endtask

    task automatic run_starts(input int n);
        for (int s = 0; s < 400 && starts.size() < n; s++) step();
    endtask

    initial begin
        int n;
        int exp_rr[8]    = '{0, 1, 2, 3, 1, 2, 4, 1};
        int exp_on[6]    = '{3, 1, 4, 3, 1, 4};
        int exp_off[6]   = '{3, 1, 4, 1, 3, 1};
        rst = 1'b1; req = '0; tier_hi = '0; retried = '0; dly_pend = '0;
        resp = '1; promo_en = 1'b0; park_bridge = 1'b0; serr_on_timeout = 1'b0;
        frame = 1'b0;

        // R1: reset state
        do_reset();
        chk("R1 reset gnt", int'(gnt), 1);
        chk("R1 reset serr", int'(serr), 0);

        // R2/R3/R4: two tiers, every requester active and responsive
        cur_req = "R2";
        tier_hi = 5'b00110;
        req = '1;
        run_starts(8);
        for (int i = 0; i < 8; i++)
            chk("R3 grant order", (i < starts.size()) ? starts[i] : -1, exp_rr[i]);
        chk("R4 low slot 1", (starts.size() > 0) ? starts[0] : -1, 0);
        chk("R4 low slot 2", (starts.size() > 3) ? starts[3] : -1, 3);
        chk("R4 low slot 3", (starts.size() > 6) ? starts[6] : -1, 4);

        // R8: parking
        cur_req = "R8";
        req = '0;
        repeat (30) step();
        chk("R8 park on last user", int'(gnt), 1 << last_user);
        park_bridge = 1'b1;
        repeat (2) step();
        chk("R8 park on bridge", int'(gnt), 1);
        park_bridge = 1'b0;

        // R6: delayed transaction promotes requester 4
        cur_req = "R6";
        tier_hi = 5'b00010; promo_en = 1'b1; dly_pend = 5'b10000;
        do_reset();
        step(); step();
        req = 5'b11010;
        run_starts(6);
        for (int i = 0; i < 6; i++)
            chk("R6 promoted order", (i < starts.size()) ? starts[i] : -1, exp_on[i]);

        // R7: enhancement off, same stimulus
        cur_req = "R7";
        promo_en = 1'b0;
        do_reset();
        step(); step();
        req = 5'b11010;
        run_starts(6);
        for (int i = 0; i < 6; i++)
            chk("R7 base order", (i < starts.size()) ? starts[i] : -1, exp_off[i]);
        dly_pend = '0;

        // R5: retry pulses, checked against the model each cycle
        cur_req = "R5";
        promo_en = 1'b1;
        do_reset();
        req = 5'b11010;
        for (int s = 0; s < 60; s++) begin
            retried = ((s % 7) == 2) ? 5'b10000 : (((s % 11) == 5) ? 5'b01000 : 5'b00000);
            step();
        end
        retried = '0;
        promo_en = 1'b0;
        step();

        // R9/R10: unresponsive master, report enabled
        cur_req = "R9";
        do_reset();
        resp = 5'b10111; serr_on_timeout = 1'b1;
        req = 5'b01000;
        for (int s = 0; s < 5 && gnt != 5'b01000; s++) step();
        n = 0;
        while (gnt == 5'b01000 && n < 40) begin step(); n++; end
        chk("R9 grant window", n, TMO);
        chk("R9 grant dropped", int'(gnt), 0);
        chk("R10 serr pulse", int'(serr), 1);
        step();
        chk("R10 serr one cycle", int'(serr), 0);
        chk("R9 re-arbitrated", int'(gnt), 8);

        // R10: report disabled
        cur_req = "R10";
        serr_on_timeout = 1'b0;
        n = 0;
        while (gnt == 5'b01000 && n < 40) begin step(); n++; end
        chk("R9 second window", n, TMO);
        chk("R10 no serr when off", int'(serr), 0);
        req = '0; resp = '1;
        repeat (20) step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule